// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Current Chopper

This controller sits beside one H-bridge and decides, every clock cycle, how the bridge is switched. When drive is requested, it drives the winding and ignores the current comparator for a blanking interval. This interval also sets the shortest possible on period. It then waits for the comparator to report that the chopping current has been reached.

A trip starts an off interval of fixed length. The first quarter of that interval uses fast decay, with the opposite switches on. The rest uses slow decay, with both low-side switches on. If the winding current reaches roughly zero during fast decay, the bridge is released to high impedance so that the current cannot reverse. When the off interval ends, a new on period with fresh blanking begins, provided drive is still requested. Dropping the request or reversing the direction ends chopping at once.

Lengths are counted in clock cycles. `BLANK_CYC` sets the blanking time, `OFF_CYC` sets the off time, and `FAST_PCT` sets the fast share of the off time. The fast part lasts FAST_CYC = OFF_CYC*FAST_PCT/100 cycles. The comparator input is asynchronous. The near-zero flag is synchronous to `clk`.

Top module: `chop_ctrl`

## Requirements
- R1: The 2-bit mode code is 2'b00 for bridge off (high impedance), 2'b01 for drive, 2'b10 for fast decay and 2'b11 for slow decay. While reset is held, and afterwards with no drive request, the code is 2'b00.
- R2: Trip reports are ignored during the first BLANK_CYC drive cycles. With the comparator held tripped, every on period shows the drive code for exactly BLANK_CYC+1 cycles.
- R3: The comparator passes through a two-flop synchronizer. A trip that rises during an on period past blanking turns the mode to fast decay on the third rising clock edge after the rise.
- R4: After a trip, fast decay lasts FAST_CYC cycles.
- R5: Slow decay follows fast decay and lasts OFF_CYC-FAST_CYC cycles.
- R6: When slow decay ends with drive still requested, a new on period with full blanking starts.
- R7: If the near-zero flag is high during fast decay, the bridge goes off from the next cycle until the fast share would have ended. Slow decay then follows, so the whole off interval keeps its OFF_CYC length.
- R8: Dropping the drive request forces mode 2'b00 on the next cycle from any state, and the mode stays there while the request is low.
- R9: A change of direction while active gives one off cycle, then a new on period with full blanking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drive_en | input | 1 | Drive request |
| drive_dir | input | 1 | Requested drive direction |
| trip_async | input | 1 | Current comparator trip, asynchronous |
| zero_i | input | 1 | Winding current near zero |
| mode_o | output | 2 | Bridge mode code |

## Verification
The bench measures how long each mode lasts, in cycles, in several situations.

- **Trip held from the start.** This exposes an off-by-one in blanking: a design with that fault shows an on period of 6 or 8 cycles where 7 are expected.
- **Trip pulse inside blanking.** A design that forgets blanking would start decay early instead of continuing to drive.
- **Trip during an on period.** A missing or extra synchronizer stage moves the fast-decay entry by one cycle.
- **Near-zero current during fast decay.** A design that leaves fast decay but restarts the off counter, or skips slow decay, gets the wrong length for the high-impedance run or the slow run.
- **Direction reversal and request removal.** A design that ignores the direction change keeps driving the winding the wrong way.

// File: rtl/chop_ctrl.sv
module chop_ctrl #(
  parameter int BLANK_CYC = 225,
  parameter int OFF_CYC   = 2500,
  parameter int FAST_PCT  = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       drive_en,
  input  logic       drive_dir,
  input  logic       trip_async,
  input  logic       zero_i,
  output logic [1:0] mode_o
);
  localparam int FAST_RAW = OFF_CYC * FAST_PCT / 100;
  localparam int FAST_CYC = (FAST_RAW < 1) ? 1 : FAST_RAW;
  localparam int MAXC     = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
  localparam int CW       = $clog2(MAXC + 1);
  localparam logic [CW-1:0] B_LAST = CW'(BLANK_CYC - 1);
  localparam logic [CW-1:0] F_LAST = CW'(FAST_CYC - 1);
  localparam logic [CW-1:0] O_LAST = CW'(OFF_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_BLANK, S_ON, S_FAST, S_HIZ, S_SLOW} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          dir_q, trip_m, trip_s;

  wire abort = (st != S_IDLE) && (!drive_en || (drive_dir != dir_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      dir_q  <= 1'b0;
      trip_m <= 1'b0;
      trip_s <= 1'b0;
    end else begin
      trip_m <= trip_async;
      trip_s <= trip_m;
      cnt    <= cnt + CW'(1);
      if (abort) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (drive_en) begin
            st    <= S_BLANK;
            cnt   <= '0;
            dir_q <= drive_dir;
          end
          S_BLANK: if (cnt == B_LAST) st <= S_ON;
          S_ON: if (trip_s) begin
            st  <= S_FAST;
            cnt <= '0;
          end
          S_FAST, S_HIZ: begin
            if (cnt == F_LAST)                st <= S_SLOW;
            else if (st == S_FAST && zero_i)  st <= S_HIZ;
          end
          S_SLOW: if (cnt == O_LAST) begin
            st  <= S_BLANK;
            cnt <= '0;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      S_BLANK, S_ON: mode_o = 2'b01;
      S_FAST:        mode_o = 2'b10;
      S_SLOW:        mode_o = 2'b11;
      default:       mode_o = 2'b00;
    endcase
  end
endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk #(
  parameter int BLANK_CYC = 225
) (
  input logic       clk,
  input logic       rst_n,
  input logic       drive_en,
  input logic       zero_i,
  input logic [1:0] mode_o
);
  localparam int RW = $clog2(BLANK_CYC + 2);
  localparam logic [RW-1:0] RMAX = RW'(BLANK_CYC);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                run_q <= '0;
    else if (mode_o != 2'b01)  run_q <= '0;
    else if (run_q != RMAX)    run_q <= run_q + RW'(1);
  end

  AST_MIN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01 && run_q < RMAX) |=> mode_o != 2'b10); // R2

  AST_FAST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10 && $past(mode_o) != 2'b10) |-> $past(mode_o) == 2'b01); // R4

  AST_SLOW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11 && $past(mode_o) != 2'b11) |-> ($past(mode_o) == 2'b10 || $past(mode_o) == 2'b00)); // R5

  AST_ZERO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10 && zero_i) |=> mode_o != 2'b10); // R7

  AST_DROP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |=> mode_o == 2'b00); // R8
endmodule

bind chop_ctrl chop_ctrl_chk #(.BLANK_CYC(BLANK_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .zero_i(zero_i), .mode_o(mode_o));

// File: tb/tb_chop_ctrl.sv
module tb_chop_ctrl;
  localparam int BLANK = 6;
  localparam int OFFC  = 20;
  localparam int FASTC = 5;

  logic clk = 1'b0, rst_n = 1'b0, drive_en = 1'b0, drive_dir = 1'b0;
  logic trip_async = 1'b0, zero_i = 1'b0;
  logic [1:0] mode_o;
  int checks = 0, failures = 0;

  chop_ctrl #(.BLANK_CYC(BLANK), .OFF_CYC(OFFC), .FAST_PCT(25)) dut (
    .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .drive_dir(drive_dir),
    .trip_async(trip_async), .zero_i(zero_i), .mode_o(mode_o));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input logic [1:0] m, output int n);
    n = 0;
    while (mode_o == m && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    drive_en = 0; trip_async = 0; zero_i = 0; drive_dir = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(mode_o == 2'b00, "R1 off in reset", mode_o, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(mode_o == 2'b00, "R1 idle without request", mode_o, 0);
  endtask

  task automatic t_chop_cycle();
    int n;
    do_reset();
    trip_async = 1; drive_en = 1;
    @(negedge clk);
    measure(2'b01, n); chk(n == BLANK + 1, "R2 on length with trip held", n, BLANK + 1);
    measure(2'b10, n); chk(n == FASTC, "R4 fast decay length", n, FASTC);
    measure(2'b11, n); chk(n == OFFC - FASTC, "R5 slow decay length", n, OFFC - FASTC);
    measure(2'b01, n); chk(n == BLANK + 1, "R6 restart with blanking", n, BLANK + 1);
    chk(mode_o == 2'b10, "R6 second fast decay", mode_o, 2);
    drive_en = 0; trip_async = 0;
    @(negedge clk);
    chk(mode_o == 2'b00, "R8 drop request in fast decay", mode_o, 0);
  endtask

  task automatic t_blank_and_sync();
    do_reset();
    drive_en = 1;
    @(negedge clk);
    trip_async = 1;
    repeat (2) @(negedge clk);
    trip_async = 0;
    repeat (13) @(negedge clk);
    chk(mode_o == 2'b01, "R2 trip in blanking ignored", mode_o, 1);
    trip_async = 1;
    @(negedge clk);
    chk(mode_o == 2'b01, "R3 edge1 still drive", mode_o, 1);
    @(negedge clk);
    chk(mode_o == 2'b01, "R3 edge2 still drive", mode_o, 1);
    @(negedge clk);
    chk(mode_o == 2'b10, "R3 edge3 fast decay", mode_o, 2);
    trip_async = 0; drive_en = 0;
    @(negedge clk);
  endtask

  task automatic t_zero();
    int n;
    do_reset();
    trip_async = 1; drive_en = 1;
    @(negedge clk);
    measure(2'b01, n);
    chk(mode_o == 2'b10, "R7 in fast decay", mode_o, 2);
    @(negedge clk);
    zero_i = 1;
    @(negedge clk);
    chk(mode_o == 2'b00, "R7 off after near zero", mode_o, 0);
    measure(2'b00, n); chk(n == 3, "R7 off until fast share ends", n, 3);
    zero_i = 0;
    chk(mode_o == 2'b11, "R7 slow decay follows", mode_o, 3);
    drive_en = 0;
    @(negedge clk);
    chk(mode_o == 2'b00, "R8 drop request in slow decay", mode_o, 0);
    repeat (5) @(negedge clk);
    chk(mode_o == 2'b00, "R8 stays off", mode_o, 0);
    trip_async = 0;
  endtask

  task automatic t_dir();
    int n;
    do_reset();
    drive_en = 1; drive_dir = 0;
    repeat (10) @(negedge clk);
    drive_dir = 1;
    @(negedge clk);
    chk(mode_o == 2'b00, "R9 off on direction change", mode_o, 0);
    @(negedge clk);
    chk(mode_o == 2'b01, "R9 drive resumes", mode_o, 1);
    trip_async = 1;
    measure(2'b01, n); chk(n == BLANK + 1, "R9 fresh blanking", n, BLANK + 1);
    drive_en = 0; trip_async = 0;
    @(negedge clk);
  endtask

  initial begin
    t_chop_cycle();
    t_blank_and_sync();
    t_zero();
    t_dir();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule